// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit sits in the operand stage of a small 8-bit microcontroller datapath. Each cycle it can take one decoded addressing-mode code together with the raw materials an operand might need: the instruction's operand byte, the working-register index, the bank bits taken from the status word, the two pointer registers, the accumulator, the 16-bit data pointer and the address of the next instruction. One clock later it reports where the operand lives. The answer is either a literal value that needs no memory access, or an address with a tag. The tag names internal RAM, the special-function register space or code memory.

Five modes are resolved: literal, direct byte address, banked working register, pointer-indirect through one of the two pointer registers, and table lookup. A table lookup forms a 16-bit code address from the accumulator plus either the data pointer or the next-instruction address. Mode codes that are not assigned produce a result flagged as not valid. The memories themselves sit outside the block.

Top module: `opnd_ea_gen`

## Requirements
- R1: While `rst` is high, at the following clock edge `out_valid`, `out_space`, `out_addr` and `out_data` all become zero.
- R2: Mode 3'd0 (literal) gives `out_data` = `op_byte`, `out_space` = 2'd0 (no memory), `out_addr` = 0 and `out_valid` = 1.
- R3: Mode 3'd1 (direct) with `op_byte` below 0x80 gives `out_addr` = `op_byte` with `out_space` = 2'd1 (internal RAM).
- R4: Mode 3'd1 with `op_byte` at 0x80 or above gives `out_addr` = `op_byte` with `out_space` = 2'd2 (special-function space).
- R5: Mode 3'd2 (register) gives `out_addr` = `bank_sel` × 8 + `reg_sel` with `out_space` = 2'd1. `bank_sel` carries status-word bits 4:3.
- R6: Mode 3'd3 (indirect) gives `out_addr` = `r1_val` when `reg_sel[0]` is 1 and `r0_val` otherwise. `out_space` is always 2'd1, even for pointer values of 0x80 and above. `reg_sel[2:1]` has no effect.
- R7: Mode 3'd4 gives `out_addr` = (`dptr` + `acc`) mod 2^16, with `acc` unsigned and `out_space` = 2'd3 (code).
- R8: Mode 3'd5 gives `out_addr` = (`pc_next` + `acc`) mod 2^16 with `out_space` = 2'd3.
- R9: Mode codes 3'd6 and 3'd7 give `out_valid` = 0, `out_addr` = 0, `out_space` = 0 and `out_data` = 0.
- R10: Results appear exactly one cycle after the request. When `in_valid` is low, the next cycle shows `out_valid` = 0. `out_data` is 0 in every mode other than literal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is present this cycle |
| mode | input | 3 | Addressing-mode code |
| op_byte | input | 8 | Operand byte from the instruction |
| reg_sel | input | 3 | Working register index; bit 0 picks the pointer in indirect mode |
| bank_sel | input | 2 | Register bank, status-word bits 4:3 |
| r0_val | input | 8 | Content of pointer register 0 |
| r1_val | input | 8 | Content of pointer register 1 |
| acc | input | 8 | Accumulator |
| dptr | input | 16 | Data pointer |
| pc_next | input | 16 | Address of the next instruction |
| out_valid | output | 1 | Result is meaningful |
| out_space | output | 2 | 0 none, 1 internal RAM, 2 special-function, 3 code |
| out_addr | output | 16 | Effective address |
| out_data | output | 8 | Literal value in literal mode |

## Verification
The assertions assume the input fields are already stable and meaningful in every cycle that has `in_valid` high, because they compare results against the inputs of the previous cycle. They make no assumption about what the unused fields contain. The stimulus sets every input at the falling edge and holds it for a whole cycle. It fills the fields that a mode ignores with distracting values, such as high pointer bits in `reg_sel` and pointer values above 0x7F. It also places indexed sums across the 16-bit wrap point and covers both unassigned mode codes.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;
    localparam int DW      = 8;
    localparam int AW      = 16;
    localparam int RIDX_W  = 3;
    localparam int BANK_W  = 2;
    localparam int SFR_BIT = DW - 1;

    typedef enum logic [2:0] {
        MD_LIT     = 3'd0,
        MD_DIRECT  = 3'd1,
        MD_REG     = 3'd2,
        MD_PTR     = 3'd3,
        MD_TBL_DP  = 3'd4,
        MD_TBL_PC  = 3'd5,
        MD_RSV_A   = 3'd6,
        MD_RSV_B   = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_IRAM = 2'd1,
        SP_SFR  = 2'd2,
        SP_CODE = 2'd3
    } space_e;

    typedef struct packed {
        logic          valid;
        space_e        space;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } ea_result_t;

    localparam ea_result_t RESULT_IDLE = '{valid: 1'b0, space: SP_NONE, addr: '0, data: '0};

    // Byte addresses at or above the top-bit boundary go to the SFR window.
    function automatic space_e direct_space(input logic [DW-1:0] a);
        return a[SFR_BIT] ? SP_SFR : SP_IRAM;
    endfunction

    function automatic logic [AW-1:0] widen(input logic [DW-1:0] b);
        return {{(AW-DW){1'b0}}, b};
    endfunction
endpackage

// File: rtl/opnd_ea_bank.sv
module opnd_ea_bank
    import opnd_ea_pkg::*;
(
    input  logic [BANK_W-1:0] bank,
    input  logic [RIDX_W-1:0] idx,
    input  logic              ptr_hi,
    input  logic [DW-1:0]     r0,
    input  logic [DW-1:0]     r1,
    output logic [DW-1:0]     reg_addr,
    output logic [DW-1:0]     ptr_addr
);
    localparam int PAD_W = DW - BANK_W - RIDX_W;

    // Working register n of bank b occupies RAM byte b*8+n.
    assign reg_addr = {{PAD_W{1'b0}}, bank, idx};
    // Only the two pointer registers may serve as an indirect address.
    assign ptr_addr = ptr_hi ? r1 : r0;
endmodule

// File: rtl/opnd_ea_index.sv
module opnd_ea_index
    import opnd_ea_pkg::*;
(
    input  logic [AW-1:0] base_dp,
    input  logic [AW-1:0] base_pc,
    input  logic          use_pc,
    input  logic [DW-1:0] offset,
    output logic [AW-1:0] sum
);
    logic [AW-1:0] base;

    assign base = use_pc ? base_pc : base_dp;
    // Unsigned offset; the carry out of the top bit is dropped.
    assign sum  = base + widen(offset);
endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
    import opnd_ea_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    mode,
    input  logic [7:0]    op_byte,
    input  logic [2:0]    reg_sel,
    input  logic [1:0]    bank_sel,
    input  logic [7:0]    r0_val,
    input  logic [7:0]    r1_val,
    input  logic [7:0]    acc,
    input  logic [15:0]   dptr,
    input  logic [15:0]   pc_next,
    output logic          out_valid,
    output logic [1:0]    out_space,
    output logic [15:0]   out_addr,
    output logic [7:0]    out_data
);
    mode_e         md;
    logic [DW-1:0] reg_addr;
    logic [DW-1:0] ptr_addr;
    logic [AW-1:0] tbl_addr;
    ea_result_t    nxt;
    ea_result_t    cur;

    assign md = mode_e'(mode);

    opnd_ea_bank u_bank (
        .bank     (bank_sel),
        .idx      (reg_sel),
        .ptr_hi   (reg_sel[0]),
        .r0       (r0_val),
        .r1       (r1_val),
        .reg_addr (reg_addr),
        .ptr_addr (ptr_addr)
    );

    opnd_ea_index u_index (
        .base_dp (dptr),
        .base_pc (pc_next),
        .use_pc  (md == MD_TBL_PC),
        .offset  (acc),
        .sum     (tbl_addr)
    );

    always_comb begin
        nxt = RESULT_IDLE;
        if (in_valid) begin
            unique case (md)
                MD_LIT: begin
                    nxt.valid = 1'b1;
                    nxt.data  = op_byte;
                end
                MD_DIRECT: begin
                    nxt.valid = 1'b1;
                    nxt.space = direct_space(op_byte);
                    nxt.addr  = widen(op_byte);
                end
                MD_REG: begin
                    nxt.valid = 1'b1;
                    nxt.space = SP_IRAM;
                    nxt.addr  = widen(reg_addr);
                end
                MD_PTR: begin
                    nxt.valid = 1'b1;
                    nxt.space = SP_IRAM;
                    nxt.addr  = widen(ptr_addr);
                end
                MD_TBL_DP, MD_TBL_PC: begin
                    nxt.valid = 1'b1;
                    nxt.space = SP_CODE;
                    nxt.addr  = tbl_addr;
                end
                default: nxt = RESULT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= RESULT_IDLE;
        else     cur <= nxt;
    end

    assign out_valid = cur.valid;
    assign out_space = cur.space;
    assign out_addr  = cur.addr;
    assign out_data  = cur.data;

    // Port-level checks, one cycle after each request.
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_addr == '0 && out_data == '0 && out_space == 2'd0));

    assert_literal_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'd0) |=>
        (out_valid && out_space == 2'd0 && out_data == $past(op_byte) && out_addr == '0));

    assert_direct_low_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'd1 && !op_byte[7]) |=>
        (out_space == 2'd1 && out_addr == {8'h00, $past(op_byte)}));

    assert_direct_high_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'd1 && op_byte[7]) |=>
        (out_space == 2'd2 && out_addr == {8'h00, $past(op_byte)}));

    assert_bank_map_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'd2) |=>
        (out_space == 2'd1 && out_addr[15:5] == '0 &&
         out_addr[4:3] == $past(bank_sel) && out_addr[2:0] == $past(reg_sel)));

    assert_ptr_iram_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'd3) |=>
        (out_space == 2'd1 &&
         out_addr[7:0] == ($past(reg_sel[0]) ? $past(r1_val) : $past(r0_val))));

    assert_table_dp_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'd4) |=>
        (out_space == 2'd3 && out_addr == 16'($past(dptr) + {8'h00, $past(acc)})));

    assert_table_pc_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 3'd5) |=>
        (out_space == 2'd3 && out_addr == 16'($past(pc_next) + {8'h00, $past(acc)})));

    assert_reserved_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode[2:1] == 2'b11) |=>
        (!out_valid && out_addr == '0 && out_space == 2'd0));

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_data_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode != 3'd0) |=> (out_data == '0));
endmodule

// File: tb/sim_opnd_ea_gen.sv
module sim_opnd_ea_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [7:0]  op_byte = '0;
    logic [2:0]  reg_sel = '0;
    logic [1:0]  bank_sel = '0;
    logic [7:0]  r0_val = '0;
    logic [7:0]  r1_val = '0;
    logic [7:0]  acc = '0;
    logic [15:0] dptr = '0;
    logic [15:0] pc_next = '0;
    logic        out_valid;
    logic [1:0]  out_space;
    logic [15:0] out_addr;
    logic [7:0]  out_data;

    typedef struct {
        logic        v;
        logic [1:0]  sp;
        logic [15:0] a;
        logic [7:0]  d;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    always #5 clk = ~clk;

    opnd_ea_gen u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .op_byte(op_byte),
        .reg_sel(reg_sel), .bank_sel(bank_sel), .r0_val(r0_val), .r1_val(r1_val),
        .acc(acc), .dptr(dptr), .pc_next(pc_next),
        .out_valid(out_valid), .out_space(out_space), .out_addr(out_addr), .out_data(out_data)
    );

    task automatic cmp(string tag, logic v, logic [1:0] sp, logic [15:0] a, logic [7:0] d);
        checks++;
        if (out_valid !== v || out_space !== sp || out_addr !== a || out_data !== d) begin
            fails++;
            $display("FAIL %s: got v=%0b sp=%0d a=%h d=%h, expected v=%0b sp=%0d a=%h d=%h",
                     tag, out_valid, out_space, out_addr, out_data, v, sp, a, d);
        end
    endtask

    // Driver: applies one request at the falling edge and queues its expected result.
    task automatic send(string tag, logic vld, logic [2:0] m, logic [7:0] ob, logic [2:0] rs,
                        logic [1:0] bk, logic [7:0] p0, logic [7:0] p1, logic [7:0] ac,
                        logic [15:0] dp, logic [15:0] pcn);
        exp_t e;
        @(negedge clk);
        in_valid = vld; mode = m; op_byte = ob; reg_sel = rs; bank_sel = bk;
        r0_val = p0; r1_val = p1; acc = ac; dptr = dp; pc_next = pcn;
        e = '{v: 1'b0, sp: 2'd0, a: 16'h0, d: 8'h0, tag: tag};
        if (vld) begin
            case (m)
                3'd0: begin e.v = 1; e.d = ob; end
                3'd1: begin e.v = 1; e.a = {8'h00, ob}; e.sp = (ob >= 8'h80) ? 2'd2 : 2'd1; end
                3'd2: begin e.v = 1; e.sp = 2'd1; e.a = 16'(bk) * 16'd8 + 16'(rs); end
                3'd3: begin e.v = 1; e.sp = 2'd1; e.a = {8'h00, (rs[0] ? p1 : p0)}; end
                3'd4: begin e.v = 1; e.sp = 2'd3; e.a = 16'((32'(dp) + 32'(ac)) % 32'h10000); end
                3'd5: begin e.v = 1; e.sp = 2'd3; e.a = 16'((32'(pcn) + 32'(ac)) % 32'h10000); end
                default: ;
            endcase
        end
        q.push_back(e);
    endtask

    // Monitor: pops one expected item per cycle just after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, e.v, e.sp, e.a, e.d);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp("R1 reset", 1'b0, 2'd0, 16'h0, 8'h0);
        rst = 1'b0;
        send("R2 literal",         1, 3'd0, 8'h6A, 3'd5, 2'd2, 8'h11, 8'h22, 8'h33, 16'h1234, 16'h5678);
        send("R2 literal ff",      1, 3'd0, 8'hFF, 3'd0, 2'd0, 8'h00, 8'h00, 8'hFF, 16'hFFFF, 16'h0000);
        send("R3 direct 00",       1, 3'd1, 8'h00, 3'd7, 2'd3, 8'hAA, 8'hBB, 8'h10, 16'h0100, 16'h0200);
        send("R3 direct 7f",       1, 3'd1, 8'h7F, 3'd1, 2'd1, 8'hAA, 8'hBB, 8'h10, 16'h0100, 16'h0200);
        send("R4 direct 80",       1, 3'd1, 8'h80, 3'd1, 2'd1, 8'hAA, 8'hBB, 8'h10, 16'h0100, 16'h0200);
        send("R4 direct ff",       1, 3'd1, 8'hFF, 3'd1, 2'd1, 8'hAA, 8'hBB, 8'h10, 16'h0100, 16'h0200);
        send("R5 bank0 r4",        1, 3'd2, 8'h9C, 3'd4, 2'd0, 8'hAA, 8'hBB, 8'h10, 16'h0100, 16'h0200);
        send("R5 bank2 r7",        1, 3'd2, 8'h9C, 3'd7, 2'd2, 8'hAA, 8'hBB, 8'h10, 16'h0100, 16'h0200);
        send("R5 bank3 r0",        1, 3'd2, 8'h9C, 3'd0, 2'd3, 8'hAA, 8'hBB, 8'h10, 16'h0100, 16'h0200);
        send("R6 ptr r0 hi sel",   1, 3'd3, 8'h55, 3'd6, 2'd1, 8'hC5, 8'h3C, 8'h10, 16'h0100, 16'h0200);
        send("R6 ptr r1 hi sel",   1, 3'd3, 8'h55, 3'd7, 2'd1, 8'hC5, 8'h3C, 8'h10, 16'h0100, 16'h0200);
        send("R6 ptr r1 above 7f", 1, 3'd3, 8'h55, 3'd1, 2'd0, 8'h00, 8'hF0, 8'h10, 16'h0100, 16'h0200);
        send("R7 dptr plain",      1, 3'd4, 8'h00, 3'd0, 2'd0, 8'h00, 8'h00, 8'h05, 16'h1000, 16'h2000);
        send("R7 dptr wrap",       1, 3'd4, 8'h00, 3'd0, 2'd0, 8'h00, 8'h00, 8'h20, 16'hFFF0, 16'h2000);
        send("R7 dptr acc ff",     1, 3'd4, 8'h00, 3'd0, 2'd0, 8'h00, 8'h00, 8'hFF, 16'h00FF, 16'h2000);
        send("R8 pc plain",        1, 3'd5, 8'h00, 3'd0, 2'd0, 8'h00, 8'h00, 8'h80, 16'h1000, 16'h0203);
        send("R8 pc wrap",         1, 3'd5, 8'h00, 3'd0, 2'd0, 8'h00, 8'h00, 8'hFF, 16'h1000, 16'hFFFF);
        send("R9 mode6",           1, 3'd6, 8'h44, 3'd3, 2'd1, 8'h12, 8'h34, 8'h56, 16'h789A, 16'hBCDE);
        send("R9 mode7",           1, 3'd7, 8'h44, 3'd3, 2'd1, 8'h12, 8'h34, 8'h56, 16'h789A, 16'hBCDE);
        send("R10 idle",           0, 3'd0, 8'h6A, 3'd0, 2'd0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000);
        send("R10 back to back",   1, 3'd1, 8'h20, 3'd0, 2'd0, 8'h00, 8'h00, 8'h00, 16'h0000, 16'h0000);
        send("R10 idle dptr",      0, 3'd4, 8'h00, 3'd0, 2'd0, 8'h00, 8'h00, 8'h11, 16'h4000, 16'h0000);
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule